// File: doc/BRIEF.md
# Sector Protection Bit Controller

This block holds the protection state of every sector of a flash array and answers, for any sector, whether a program or erase may touch it. Each sector has two protection bits. The persistent bit can be cleared one sector at a time, but it can only be set again by a single command that restores every sector together. The volatile bit can be set or cleared freely, one sector at a time. A global volatile lock freezes all persistent bits once it is engaged, and only a reset releases it. A low-active write-protect pin also forces one boundary sector into the protected state. The parameter `WP_TOP` picks which end of the array that sector is on.

A command decoder ahead of this block turns bus cycles into single-cycle strobes and a sector number. The block updates its bits on the clock edge that samples a strobe. The embedded program and erase logic reads `queryProtected` for the sector it is about to modify. A status strobe returns the persistent bit of a sector as a one-byte code. Two resets are supplied. `rstN` models a hardware reset and leaves the persistent bits intact. `porN` models power-up and also restores the persistent bits to their shipped value.

Top module: `sector_protect_unit`

## Requirements
- R1: After power-up every persistent bit and every volatile bit reads 1, the lock is released, no sector is reported protected while `wpN` is high, and `statusValid` is 0.
- R2: An IPB-program strobe clears the persistent bit of `cmdSector` only. Persistent bits never go from 0 to 1 except through the erase-all strobe, which sets all of them in one cycle.
- R3: While the lock is engaged, the IPB-program and erase-all strobes leave every persistent bit unchanged.
- R4: The lock-set strobe engages the lock. No strobe releases it. `rstN` low or `porN` low releases it.
- R5: The DPB-set strobe clears the volatile bit of `cmdSector` and the DPB-clear strobe sets it. A sector is protected when its persistent bit is 0, or its volatile bit is 0, or the write-protect override applies to it.
- R6: `rstN` low restores all volatile bits to 1 and keeps the persistent bits. `porN` low restores both kinds of bit to 1.
- R7: While `wpN` is 0, sector NUM_SECTORS-1 (when WP_TOP=1) or sector 0 (when WP_TOP=0) is reported protected whatever its bits hold. While `wpN` is 1, that sector follows its bits.
- R8: In the cycle after a status strobe, `statusValid` is 1 for one cycle. `statusData` is 8'h00 if the persistent bit of the sampled `cmdSector` was 0 and 8'h01 if it was 1. The code reflects only the persistent bit, not the volatile bit.
- R9: When several modifying strobes arrive in one cycle, only the highest one acts, in the order erase-all, IPB-program, DPB-set, DPB-clear, lock-set. The lock gates the selected strobe after this choice is made.
- R10: `queryProtected` depends combinationally on `querySector` and `wpN`, and reflects a command from the clock edge that sampled its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| porN | input | 1 | Power-up reset, active low, asynchronous |
| cmdIpbProg | input | 1 | Clear persistent bit of cmdSector |
| cmdIpbEraseAll | input | 1 | Set all persistent bits |
| cmdDpbSet | input | 1 | Protect cmdSector through its volatile bit |
| cmdDpbClear | input | 1 | Unprotect cmdSector through its volatile bit |
| cmdLockSet | input | 1 | Engage the persistent-bit lock |
| cmdStatusRd | input | 1 | Request persistent-bit status of cmdSector |
| cmdSector | input | SEC_W | Sector addressed by a strobe |
| wpN | input | 1 | Write-protect pin, low protects the boundary sector |
| querySector | input | SEC_W | Sector whose protection is reported |
| queryProtected | output | 1 | 1 when querySector may not be programmed or erased |
| statusValid | output | 1 | Status byte valid |
| statusData | output | 8 | 8'h00 protected, 8'h01 unprotected persistent bit |

## Verification
The hardest states to reach are the ones where the lock is engaged while some persistent bits are already cleared, combined with a hardware reset that must release the lock and volatile bits but preserve those persistent bits. The lock closes off further persistent-bit changes. Random stimulus therefore issues lock-set rarely, so that persistent bits have time to accumulate. It also pulses `rstN` periodically to reopen the lock, and `porN` less often to wipe everything. Directed steps cover same-cycle strobe collisions, such as IPB-program together with lock-set, and erase-all attempted under the lock.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // One decoded, priority-resolved, lock-gated operation per cycle
  typedef struct packed {
    logic ipbProg;
    logic ipbEraseAll;
    logic dpbSet;
    logic dpbClear;
    logic lockSet;
    logic statusRd;
  } sgOps_t;

endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
(
  input  logic   clk,
  input  logic   volRstN,
  input  logic   cmdIpbProg,
  input  logic   cmdIpbEraseAll,
  input  logic   cmdDpbSet,
  input  logic   cmdDpbClear,
  input  logic   cmdLockSet,
  input  logic   cmdStatusRd,
  output sgOps_t ops,
  output logic   lockN
);

  sgOps_t pick;

  // Priority choice first (R9), lock gating second (R3)
  always_comb begin
    pick          = '0;
    pick.statusRd = cmdStatusRd;
    if (cmdIpbEraseAll)   pick.ipbEraseAll = 1'b1;
    else if (cmdIpbProg)  pick.ipbProg     = 1'b1;
    else if (cmdDpbSet)   pick.dpbSet      = 1'b1;
    else if (cmdDpbClear) pick.dpbClear    = 1'b1;
    else if (cmdLockSet)  pick.lockSet     = 1'b1;
  end

  always_comb begin
    ops = pick;
    if (!lockN) begin
      ops.ipbProg     = 1'b0;
      ops.ipbEraseAll = 1'b0;
    end
  end

  // Volatile lock: engaged by command, released only by reset (R4)
  always_ff @(posedge clk or negedge volRstN) begin
    if (!volRstN)         lockN <= 1'b1;
    else if (ops.lockSet) lockN <= 1'b0;
  end

  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!volRstN)
    !lockN |=> !lockN);

  p_lock_engage_r4: assert property (@(posedge clk) disable iff (!volRstN)
    (cmdLockSet && !cmdIpbEraseAll && !cmdIpbProg && !cmdDpbSet && !cmdDpbClear) |=> !lockN);

endmodule

// File: rtl/sg_bits.sv
module sg_bits
  import sg_pkg::*;
#(
  parameter int NUM_SECTORS = 128,
  parameter int SEC_W       = 7,
  parameter int WP_IDX      = 127
) (
  input  logic                   clk,
  input  logic                   porN,
  input  logic                   volRstN,
  input  sgOps_t                 ops,
  input  logic [SEC_W-1:0]       opSector,
  input  logic                   wpN,
  input  logic [SEC_W-1:0]       querySector,
  output logic [NUM_SECTORS-1:0] ipbVec,
  output logic                   queryProtected,
  output logic                   statusValid,
  output logic [7:0]             statusData
);

  logic [NUM_SECTORS-1:0] dpbVec;
  logic [NUM_SECTORS-1:0] protVec;
  logic                   selIpb;

  for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sector
    localparam logic [SEC_W-1:0] SelfIdx = SEC_W'(s);
    logic hit;
    assign hit = (opSector == SelfIdx);

    // Persistent-style bit: only power-up or erase-all raise it (R2, R6)
    always_ff @(posedge clk or negedge porN) begin
      if (!porN)                  ipbVec[s] <= 1'b1;
      else if (ops.ipbEraseAll)   ipbVec[s] <= 1'b1;
      else if (ops.ipbProg && hit) ipbVec[s] <= 1'b0;
    end

    // Volatile bit, individually set/cleared (R5)
    always_ff @(posedge clk or negedge volRstN) begin
      if (!volRstN)                 dpbVec[s] <= 1'b1;
      else if (ops.dpbSet && hit)   dpbVec[s] <= 1'b0;
      else if (ops.dpbClear && hit) dpbVec[s] <= 1'b1;
    end

    if (s == WP_IDX) begin : g_wp
      assign protVec[s] = !ipbVec[s] || !dpbVec[s] || !wpN;
    end else begin : g_plain
      assign protVec[s] = !ipbVec[s] || !dpbVec[s];
    end
  end

  always_comb begin
    queryProtected = 1'b1;
    if (int'(querySector) < NUM_SECTORS) queryProtected = protVec[querySector];
  end

  always_comb begin
    selIpb = 1'b1;
    if (int'(opSector) < NUM_SECTORS) selIpb = ipbVec[opSector];
  end

  always_ff @(posedge clk or negedge volRstN) begin
    if (!volRstN) begin
      statusValid <= 1'b0;
      statusData  <= 8'h00;
    end else begin
      statusValid <= ops.statusRd;
      if (ops.statusRd) statusData <= {7'b0, selIpb};
    end
  end

  p_ipb_no_rise_r2: assert property (@(posedge clk) disable iff (!porN)
    !ops.ipbEraseAll |=> ((~$past(ipbVec)) & ipbVec) == '0);

  p_erase_sets_all_r2: assert property (@(posedge clk) disable iff (!porN)
    ops.ipbEraseAll |=> (&ipbVec));

  p_dpb_after_reset_r6: assert property (@(posedge clk) disable iff (!porN)
    $rose(volRstN) |-> (&dpbVec));

  p_status_code_r8: assert property (@(posedge clk) disable iff (!volRstN)
    statusValid |-> (statusData[7:1] == 7'd0));

endmodule

// File: rtl/sector_protect_unit.sv
module sector_protect_unit
  import sg_pkg::*;
#(
  parameter int  NUM_SECTORS = 128,
  parameter bit  WP_TOP      = 1'b1,
  localparam int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             cmdIpbProg,
  input  logic             cmdIpbEraseAll,
  input  logic             cmdDpbSet,
  input  logic             cmdDpbClear,
  input  logic             cmdLockSet,
  input  logic             cmdStatusRd,
  input  logic [SEC_W-1:0] cmdSector,
  input  logic             wpN,
  input  logic [SEC_W-1:0] querySector,
  output logic             queryProtected,
  output logic             statusValid,
  output logic [7:0]       statusData
);

  localparam int WP_IDX = WP_TOP ? NUM_SECTORS - 1 : 0;

  logic                   volRstN;
  sgOps_t                 ops;
  logic                   lockN;
  logic [NUM_SECTORS-1:0] ipbVec;

  assign volRstN = rstN & porN;

  sg_ctrl i_ctrl (
    .clk            (clk),
    .volRstN        (volRstN),
    .cmdIpbProg     (cmdIpbProg),
    .cmdIpbEraseAll (cmdIpbEraseAll),
    .cmdDpbSet      (cmdDpbSet),
    .cmdDpbClear    (cmdDpbClear),
    .cmdLockSet     (cmdLockSet),
    .cmdStatusRd    (cmdStatusRd),
    .ops            (ops),
    .lockN          (lockN)
  );

  sg_bits #(
    .NUM_SECTORS (NUM_SECTORS),
    .SEC_W       (SEC_W),
    .WP_IDX      (WP_IDX)
  ) i_bits (
    .clk            (clk),
    .porN           (porN),
    .volRstN        (volRstN),
    .ops            (ops),
    .opSector       (cmdSector),
    .wpN            (wpN),
    .querySector    (querySector),
    .ipbVec         (ipbVec),
    .queryProtected (queryProtected),
    .statusValid    (statusValid),
    .statusData     (statusData)
  );

  p_ipb_frozen_r3: assert property (@(posedge clk) disable iff (!volRstN)
    !lockN |=> $stable(ipbVec));

endmodule

// File: tb/test_sector_protect_unit.sv
`timescale 1ns/1ps
module test_sector_protect_unit;

  localparam int N    = 128;
  localparam int SW   = $clog2(N);
  localparam int WPI  = N - 1;

  logic clk = 1'b0;
  logic rstN, porN;
  logic cmdIpbProg, cmdIpbEraseAll, cmdDpbSet, cmdDpbClear, cmdLockSet, cmdStatusRd;
  logic [SW-1:0] cmdSector, querySector;
  logic wpN;
  logic queryProtected, statusValid;
  logic [7:0] statusData;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  bit expIpb [N];
  bit expDpb [N];
  bit expLockN;

  always #2 clk = ~clk;

  sector_protect_unit #(.NUM_SECTORS(N), .WP_TOP(1'b1)) i_sector_protect_unit (
    .clk(clk), .rstN(rstN), .porN(porN),
    .cmdIpbProg(cmdIpbProg), .cmdIpbEraseAll(cmdIpbEraseAll),
    .cmdDpbSet(cmdDpbSet), .cmdDpbClear(cmdDpbClear),
    .cmdLockSet(cmdLockSet), .cmdStatusRd(cmdStatusRd),
    .cmdSector(cmdSector), .wpN(wpN), .querySector(querySector),
    .queryProtected(queryProtected), .statusValid(statusValid), .statusData(statusData)
  );

  function automatic bit expProt(int s, bit wp);
    return !expIpb[s] || !expDpb[s] || (s == WPI && !wp);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic checkQuery(int s, string req);
    querySector = SW'(s);
    #0.2;
    chk(queryProtected == expProt(s, wpN), req, queryProtected, expProt(s, wpN));
  endtask

  task automatic modelReset(bit pwr);
    for (int s = 0; s < N; s++) begin
      expDpb[s] = 1'b1;
      if (pwr) expIpb[s] = 1'b1;
    end
    expLockN = 1'b1;
  endtask

  // Drive strobes at a negedge, model the edge, check status at next negedge
  task automatic doCmd(bit ep, bit ip, bit ds, bit dc, bit ls, bit sr, int sec);
    bit stat;
    @(negedge clk);
    cmdIpbEraseAll = ep; cmdIpbProg = ip; cmdDpbSet = ds;
    cmdDpbClear = dc; cmdLockSet = ls; cmdStatusRd = sr; cmdSector = SW'(sec);
    stat = expIpb[sec];
    @(posedge clk);
    if (ep)      begin if (expLockN) for (int s = 0; s < N; s++) expIpb[s] = 1'b1; end
    else if (ip) begin if (expLockN) expIpb[sec] = 1'b0; end
    else if (ds) expDpb[sec] = 1'b0;
    else if (dc) expDpb[sec] = 1'b1;
    else if (ls) expLockN = 1'b0;
    @(negedge clk);
    {cmdIpbEraseAll, cmdIpbProg, cmdDpbSet, cmdDpbClear, cmdLockSet, cmdStatusRd} = '0;
    if (sr) chk(statusValid && statusData == {7'b0, stat}, "R8 status",
                {statusValid, statusData}, {1'b1, 7'b0, stat});
    else    chk(!statusValid, "R8 valid idle", statusValid, 0);
  endtask

  task automatic pulseReset(bit pwr);
    @(negedge clk);
    if (pwr) porN = 1'b0; else rstN = 1'b0;
    @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    modelReset(pwr);
  endtask

  initial begin
    #700000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h5EC7_0A11);
    {cmdIpbEraseAll, cmdIpbProg, cmdDpbSet, cmdDpbClear, cmdLockSet, cmdStatusRd} = '0;
    cmdSector = '0; querySector = '0; wpN = 1'b1;
    rstN = 1'b0; porN = 1'b0;
    modelReset(1'b1);
    repeat (3) @(negedge clk);
    rstN = 1'b1; porN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!statusValid, "R1 statusValid", statusValid, 0);
    for (int s = 0; s < N; s++) checkQuery(s, "R1 unprotected");

    // R7 write-protect override on top sector
    wpN = 1'b0;
    checkQuery(WPI, "R7 wp low protects boundary");
    checkQuery(0, "R7 other end free");
    wpN = 1'b1;
    checkQuery(WPI, "R7 wp high follows bits");

    // R2 / R8 single IPB program and status codes
    doCmd(0,1,0,0,0,0, 5);
    checkQuery(5, "R2 ipb program protects");
    checkQuery(6, "R2 neighbour untouched");
    doCmd(0,0,0,0,0,1, 5);
    doCmd(0,0,0,0,0,1, 6);

    // R5 DPB set / clear; status ignores DPB (R8)
    doCmd(0,0,1,0,0,0, 9);
    checkQuery(9, "R5 dpb set protects");
    doCmd(0,0,0,0,0,1, 9);
    doCmd(0,0,0,1,0,0, 9);
    checkQuery(9, "R5 dpb clear unprotects");

    // R2 erase-all restores
    doCmd(1,0,0,0,0,0, 0);
    checkQuery(5, "R2 erase-all restores");

    // R9 IPB program beats lock set in same cycle
    doCmd(0,1,0,0,1,0, 3);
    checkQuery(3, "R9 ipb program won");
    doCmd(0,1,0,0,0,0, 4);
    checkQuery(4, "R9 lock not engaged");
    // R9 erase-all beats DPB set
    doCmd(1,0,1,0,0,0, 20);
    checkQuery(20, "R9 dpb set dropped");
    doCmd(0,1,0,0,0,0, 3);

    // R3 / R4 lock freezes IPBs
    doCmd(0,0,0,0,1,0, 0);
    doCmd(0,1,0,0,0,0, 7);
    checkQuery(7, "R3 locked program ignored");
    doCmd(1,0,0,0,0,0, 0);
    checkQuery(3, "R3 locked erase ignored");
    doCmd(0,0,1,0,0,0, 11);
    checkQuery(11, "R5 dpb works while locked");

    // R6 hardware reset keeps IPB, clears DPB and lock (R4)
    pulseReset(1'b0);
    checkQuery(3, "R6 ipb kept on hw reset");
    checkQuery(11, "R6 dpb cleared on hw reset");
    doCmd(0,1,0,0,0,0, 7);
    checkQuery(7, "R4 lock released by reset");

    // R6 power-up clears all
    pulseReset(1'b1);
    checkQuery(3, "R6 power-up clears ipb");
    checkQuery(7, "R6 power-up clears ipb");

    // Random phase (R10 query after each command)
    for (int it = 0; it < 3000; it++) begin
      int r, sec;
      bit ep, ip, ds, dc, ls, sr;
      r   = $urandom;
      sec = $urandom_range(N-1, 0);
      if (r[7:0] < 40) sec = WPI;
      ep = (r[12:8] == 0);
      ip = r[13] & r[14];
      ds = r[15] & r[16];
      dc = r[17] & r[18];
      ls = (r[24:19] == 0);
      sr = r[25];
      wpN = r[26] | r[27];
      doCmd(ep, ip, ds, dc, ls, sr, sec);
      checkQuery(sec, "R10 query after command");
      checkQuery($urandom_range(N-1, 0), "R5 random sector");
      checkQuery(WPI, "R7 boundary");
      if (it % 250 == 249)  pulseReset(1'b0);
      if (it % 1100 == 1099) pulseReset(1'b1);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule